// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the read and write strobes for programmed-I/O transfers on an ATA channel shared by two drives. Each transfer runs as three back-to-back phases: an address-setup phase with both strobes idle, an active phase with the read or write strobe low, and a recovery phase with both strobes idle again. The length of each phase is a clock count that software programs in advance. The address-setup count is shared by the whole channel. The active and recovery counts are held separately for each drive and for each direction.

A start pulse, together with the drive number and the read/write flag, launches one transfer. On that pulse the block takes a snapshot of the selected drive's timing byte. It keeps `busy` high until recovery has finished, and then raises `done` for one clock. The shared configuration byte also carries a read-prefetch flag and a ready-wait count, and the block presents both of them decoded. The sequencer has four states. IDLE goes to SETUP on an accepted start. SETUP goes to ACTIVE when the setup count expires. ACTIVE goes to RECOVER when the pulse count expires. RECOVER goes back to IDLE when the recovery count expires, and that transition raises `done`.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset both strobes are high and `busy` and `done` are low. Every timing byte and the shared byte reset to zero, so the first transfer runs 1 setup, 1 active and 2 recovery clocks, `prefetch_en` is 0 and `ready_wait` is 2.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored at `cfg_addr`. Address 2*d+w holds the cycle byte of drive d, where w=1 selects the write byte and w=0 the read byte. Address 4 holds the shared byte. Addresses 5 to 7 store nothing.
- R3: The setup phase lasts (shared byte bits 5:4) + 1 clocks, from 1 to 4. It starts in the first cycle after the edge that accepts start. Both strobes are high and `busy` is high during this phase.
- R4: The active phase lasts (cycle byte bits 7:4) + 1 clocks, from 1 to 16. A read drives `dior_n` low and a write drives `diow_n` low, and only during this phase.
- R5: The recovery phase lasts (cycle byte bits 3:0) + 2 clocks, from 2 to 17. Both strobes are high and `busy` stays high during this phase.
- R6: The cycle byte used for a transfer is the one at address 2*`drv_sel`+`is_write`, captured when start is accepted.
- R7: `done` is high for exactly one clock, in the first cycle after recovery ends, and `busy` is low in that cycle. A start given in that cycle is accepted, which makes transfers back to back.
- R8: A start while `busy` is high is ignored. Changes on `drv_sel` and `is_write` during a transfer have no effect on it.
- R9: A configuration write made while a transfer runs, or in the same cycle as the accepted start, affects only later transfers.
- R10: `prefetch_en` equals bit 6 of the shared byte. `ready_wait` equals (shared byte bits 2:1) + 2.
- R11: `dior_n` and `diow_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| start | input | 1 | Transfer request, taken only in IDLE |
| drv_sel | input | 1 | Drive number for the transfer |
| is_write | input | 1 | 1 for a write transfer, 0 for a read |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| busy | output | 1 | High from the accepted start until recovery ends |
| done | output | 1 | One-clock completion pulse |
| prefetch_en | output | 1 | Decoded read-prefetch flag |
| ready_wait | output | 3 | Decoded ready-wait count, from 2 to 5 |

## Verification
Two pairs of events can fall in the same cycle, and both pairs are exercised. The first pair is the completion pulse and a new start. The bench raises start in the very cycle where `done` is seen and then expects a fresh setup phase with no idle gap. The second pair is an accepted start and a write to the timing byte that this start selects. The bench computes the phase lengths of the running transfer from the old byte and those of the following transfer from the new byte. Random mid-transfer writes to the cycle bytes and the shared byte are judged the same way.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_RECOVER = 2'd3
    } pio_phase_e;

    localparam int BYTE_W  = 8;
    localparam int PF_BIT  = 6;
    localparam int SET_LSB = 4;
    localparam int RDY_LSB = 1;
    localparam int RDY_W   = 2;

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_timing_pkg::*;
#(
    parameter int N_DRV  = 2,
    parameter int SET_W  = 2,
    parameter int ADDR_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [BYTE_W-1:0]                  wdata,
    output logic [2*N_DRV-1:0][BYTE_W-1:0]     cyc_q,
    output logic                               pf_q,
    output logic [SET_W-1:0]                   set_q,
    output logic [RDY_W-1:0]                   rdy_q
);
    localparam int N_CYC = 2 * N_DRV;

    for (genvar g = 0; g < N_CYC; g++) begin : g_cyc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cyc_q[g] <= '0;
            end else if (we && addr == ADDR_W'(g)) begin
                cyc_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q  <= 1'b0;
            set_q <= '0;
            rdy_q <= '0;
        end else if (we && addr == ADDR_W'(N_CYC)) begin
            pf_q  <= wdata[PF_BIT];
            set_q <= wdata[SET_LSB +: SET_W];
            rdy_q <= wdata[RDY_LSB +: RDY_W];
        end
    end

endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select
    import pio_timing_pkg::*;
#(
    parameter int N_DRV = 2,
    parameter int DRV_W = 1,
    parameter int ACT_W = 4,
    parameter int REC_W = 4
) (
    input  logic [2*N_DRV-1:0][BYTE_W-1:0] cyc,
    input  logic [DRV_W-1:0]               drv,
    input  logic                           is_wr,
    output logic [ACT_W-1:0]               act_fld,
    output logic [REC_W-1:0]               rec_fld
);
    localparam int IDX_W = DRV_W + 1;

    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] pick;

    always_comb begin
        idx     = {drv, is_wr};
        pick    = cyc[idx];
        act_fld = pick[BYTE_W-1 -: ACT_W];
        rec_fld = pick[REC_W-1:0];
    end

endmodule

// File: rtl/pio_phase_counter.sv
module pio_phase_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
    import pio_timing_pkg::*;
#(
    parameter int N_DRV = 2,
    parameter int ACT_W = 4,
    parameter int REC_W = 4,
    parameter int SET_W = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [$clog2(2*N_DRV+1)-1:0]           cfg_addr,
    input  logic [7:0]                             cfg_wdata,
    input  logic                                   start,
    input  logic [((N_DRV > 1) ? $clog2(N_DRV) : 1)-1:0] drv_sel,
    input  logic                                   is_write,
    output logic                                   dior_n,
    output logic                                   diow_n,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   prefetch_en,
    output logic [2:0]                             ready_wait
);
    localparam int DRV_W  = (N_DRV > 1) ? $clog2(N_DRV) : 1;
    localparam int ADDR_W = $clog2(2*N_DRV+1);
    localparam int CNT_W  = ((ACT_W > REC_W) ? ACT_W : REC_W) + 1;

    logic [2*N_DRV-1:0][BYTE_W-1:0] cyc_q;
    logic                           pf_q;
    logic [SET_W-1:0]               set_q;
    logic [RDY_W-1:0]               rdy_q;
    logic [ACT_W-1:0]               sel_act;
    logic [REC_W-1:0]               sel_rec;

    pio_phase_e       state_q, state_d;
    logic [ACT_W-1:0] snap_act;
    logic [REC_W-1:0] snap_rec;
    logic             snap_wr;
    logic             done_q, done_d;
    logic             take;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;

    pio_cfg_regs #(
        .N_DRV  (N_DRV),
        .SET_W  (SET_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cyc_q (cyc_q),
        .pf_q  (pf_q),
        .set_q (set_q),
        .rdy_q (rdy_q)
    );

    pio_timing_select #(
        .N_DRV (N_DRV),
        .DRV_W (DRV_W),
        .ACT_W (ACT_W),
        .REC_W (REC_W)
    ) u_sel (
        .cyc     (cyc_q),
        .drv     (drv_sel),
        .is_wr   (is_write),
        .act_fld (sel_act),
        .rec_fld (sel_rec)
    );

    pio_phase_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        done_d  = 1'b0;
        take    = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    state_d = PH_SETUP;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(set_q);
                    take    = 1'b1;
                end
            end
            PH_SETUP: begin
                if (expired) begin
                    state_d = PH_ACTIVE;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(snap_act);
                end
            end
            PH_ACTIVE: begin
                if (expired) begin
                    state_d = PH_RECOVER;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(snap_rec) + CNT_W'(1);
                end
            end
            PH_RECOVER: begin
                if (expired) begin
                    state_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register with per-transfer snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            done_q   <= 1'b0;
            snap_act <= '0;
            snap_rec <= '0;
            snap_wr  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (take) begin
                snap_act <= sel_act;
                snap_rec <= sel_rec;
                snap_wr  <= is_write;
            end
        end
    end

    // outputs from state
    always_comb begin
        busy        = (state_q != PH_IDLE);
        dior_n      = !((state_q == PH_ACTIVE) && !snap_wr);
        diow_n      = !((state_q == PH_ACTIVE) &&  snap_wr);
        done        = done_q;
        prefetch_en = pf_q;
        ready_wait  = {1'b0, rdy_q} + 3'd2;
    end

endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic dior_n,
    input logic diow_n,
    input logic busy,
    input logic done
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R11

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> busy); // R4

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && dior_n && diow_n)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7

    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(dior_n && diow_n)); // R5

endmodule

bind pio_strobe_timer pio_strobe_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .dior_n (dior_n),
    .diow_n (diow_n),
    .busy   (busy),
    .done   (done)
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       start = 1'b0;
    logic [0:0] drv_sel = '0;
    logic       is_write = 1'b0;
    logic       dior_n, diow_n, busy, done, prefetch_en;
    logic [2:0] ready_wait;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  ended = 0;
    logic [7:0] sh_cyc [4];
    logic [7:0] sh_misc;

    always #5 clk = ~clk;

    pio_strobe_timer u0 (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .start (start), .drv_sel (drv_sel),
        .is_write (is_write), .dior_n (dior_n), .diow_n (diow_n),
        .busy (busy), .done (done), .prefetch_en (prefetch_en),
        .ready_wait (ready_wait)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // {dior_n, diow_n, busy, done} during transfer clock i
    function automatic logic [3:0] exp_pins(int i, int s, int a, bit w);
        if (i < s) return 4'b1110;
        if (i < s + a) return w ? 4'b1010 : 4'b0110;
        return 4'b1110;
    endfunction

    function automatic void shadow_put(int addr, logic [7:0] v);
        if (addr < 4) sh_cyc[addr] = v;
        else if (addr == 4) sh_misc = v;
    endfunction

    // called at a negedge, returns at a negedge
    task automatic cfg_write(int addr, logic [7:0] v);
        cfg_we = 1; cfg_addr = 3'(addr); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
        shadow_put(addr, v);
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        check(tag, {dior_n, diow_n, busy, done}, 4'b1100);
    endtask

    // poke: 0 none, 1 same-cycle byte write, 2 mid byte write, 3 mid shared write
    task automatic do_cycle(int d, bit w, bit hold, int poke, string tag);
        int idx = 2*d + int'(w);
        int s = int'(sh_misc[5:4]) + 1;
        int a = int'(sh_cyc[idx][7:4]) + 1;
        int r = int'(sh_cyc[idx][3:0]) + 2;
        int paddr = (poke == 3) ? 4 : idx;
        logic [7:0] nv = 8'($urandom);
        start = 1; drv_sel = 1'(d); is_write = w;
        if (poke == 1) begin cfg_we = 1; cfg_addr = 3'(paddr); cfg_wdata = nv; end
        @(negedge clk);
        if (poke == 1) begin cfg_we = 0; shadow_put(paddr, nv); end
        start = hold;
        for (int i = 0; i < s + a + r; i++) begin
            if (hold) begin drv_sel = 1'($urandom); is_write = 1'($urandom); end
            if (poke >= 2 && i == 0) begin cfg_we = 1; cfg_addr = 3'(paddr); cfg_wdata = nv; end
            if (poke >= 2 && i == 1) begin cfg_we = 0; shadow_put(paddr, nv); end
            check(tag, {dior_n, diow_n, busy, done}, exp_pins(i, s, a, w));
            @(negedge clk);
        end
        start = 0;
        check({tag, " R7 done"}, {dior_n, diow_n, busy, done}, 4'b1101);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 4; k++) sh_cyc[k] = 8'h00;
        sh_misc = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 pins", {dior_n, diow_n, busy, done}, 4'b1100);
        check("R1 prefetch", prefetch_en, 0);
        check("R1 ready_wait", ready_wait, 2);
        do_cycle(0, 0, 0, 0, "R1 shortest read");
        idle_check("R1 idle");

        // R2 / R6: distinct bytes per drive and direction
        cfg_write(0, 8'h21);
        cfg_write(1, 8'h13);
        cfg_write(2, 8'h40);
        cfg_write(3, 8'h05);
        cfg_write(4, 8'h10);
        cfg_write(5, 8'hFF);
        check("R2 unused addr", {prefetch_en, ready_wait}, {1'b0, 3'd2});
        do_cycle(0, 0, 0, 0, "R6 d0 read");
        idle_check("R6 idle");
        do_cycle(0, 1, 0, 0, "R6 d0 write");
        idle_check("R6 idle");
        do_cycle(1, 0, 0, 0, "R6 d1 read");
        idle_check("R6 idle");
        do_cycle(1, 1, 0, 0, "R6 d1 write");
        idle_check("R6 idle");

        // R3 R4 R5 maxima
        cfg_write(4, 8'h30);
        cfg_write(3, 8'hFF);
        do_cycle(1, 1, 0, 0, "R4 R5 max write");
        idle_check("R5 idle");

        // R10 decode
        cfg_write(4, 8'h46);
        check("R10 prefetch", prefetch_en, 1);
        check("R10 ready_wait", ready_wait, 5);
        cfg_write(4, 8'h02);
        check("R10 prefetch off", prefetch_en, 0);
        check("R10 ready_wait 3", ready_wait, 3);

        // R7 back to back
        do_cycle(0, 0, 0, 0, "R7 first");
        do_cycle(1, 1, 0, 0, "R7 chained");
        idle_check("R7 idle");

        // R8 start held while busy
        do_cycle(0, 1, 1, 0, "R8 held start");
        idle_check("R8 idle");

        // R9 config writes during and with start
        do_cycle(1, 0, 0, 1, "R9 same cycle");
        do_cycle(1, 0, 0, 0, "R9 next uses new");
        do_cycle(0, 1, 0, 2, "R9 mid byte");
        do_cycle(0, 1, 0, 3, "R9 mid shared");
        do_cycle(0, 1, 0, 0, "R9 after shared");
        idle_check("R9 idle");

        // random mix
        for (int n = 0; n < 80; n++) begin
            int pick = $urandom_range(0, 9);
            if (pick < 3) cfg_write($urandom_range(0, 4), 8'($urandom));
            do_cycle($urandom_range(0, 1), 1'($urandom), 1'($urandom),
                     $urandom_range(0, 3), "R3 R4 R5 R9 random");
            if ($urandom_range(0, 1) == 1) idle_check("R8 random idle");
        end

        summary();
    end

endmodule